// File: doc/BRIEF.md
# Windowed Toggle-Refresh Watchdog

This block is a watchdog timer that software keeps alive by writing bit 0 of a trigger register. Each write must carry the value opposite to the previous accepted one. Each write must also land inside a window that spans from 75% to 125% of a selectable refresh period. A refresh that comes too early, too late or with a repeated value is a fault. A fault raises a sticky timeout status, and an optional interrupt follows that status.

Timing comes from a clock-enable input `tick_i`. A prescaler divides it by `TICK_DIV` to give one millisecond step. The period is `BASE_MS << code` milliseconds, where the code is 0 to 4. With the default `BASE_MS = 125` the periods are 125 ms, 250 ms, 500 ms, 1 s and 2 s. Software reaches the registers through a simple write port and an address-selected read port.

Top module: `toggle_wdog`

## Requirements
- R1: After reset every register reads 0, and `timeout_o` and `irq_o` are low. The register map is: address 0 control (bit 0 enable, bit 1 interrupt enable), address 1 trigger (bit 0), address 2 period code (bits 2:0), address 3 status (bit 0 timeout).
- R2: Period codes 0 to 4 select `BASE_MS << code` ms. Codes 5 to 7 select the same period as code 4.
- R3: With period P, a trigger write is accepted when the elapsed ms count E since the last restart satisfies P-P/4 <= E <= P+P/4. A write with E < P-P/4 is a fault.
- R4: When E reaches P+P/4+1 without a trigger write, a fault is raised and the count restarts from 0.
- R5: A trigger write is accepted only if bit 0 differs from the last accepted value. The first value after enable must be 1. A repeated value is a fault. Trigger reads return the last accepted value.
- R6: A fault sets the status bit, which stays set until address 3 is written with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R7: `timeout_o` follows the status bit. `irq_o` is the status bit ANDed with control bit 1.
- R8: While control bit 0 is 0, the count is held at 0, trigger writes are ignored and no fault occurs. Enabling the block therefore restarts the window.
- R9: The ms step fires once every `TICK_DIV` cycles with `tick_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock-enable timebase pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| timeout_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | Timeout interrupt |

## Verification
A register write changes the register state, and any fault it causes, at the same clock edge that captures it. The bench drives on the falling edge and samples on the next falling edge. A ms step raises the count two edges after the tick pulse: one edge in the prescaler and one in the counter. A late fault shows on `timeout_o` one edge after the count passes the window. For this reason the tick task always ends with two idle cycles before any check. The read port is combinational, so readbacks are sampled on the same falling edge at which the address is set.

// File: rtl/toggle_wdog_pkg.sv
package toggle_wdog_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TRIG = 2'd1;
  localparam logic [1:0] A_CODE = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int unsigned MAX_CODE = 4;

  function automatic int unsigned period_ms(input logic [2:0] code, input int unsigned base);
    int unsigned c;
    c = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    return base << c;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ms_tick_o
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_pass
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ms_tick_o <= 1'b0;
        else         ms_tick_o <= tick_i;
      end
    end else begin : g_div
      logic [DW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q     <= '0;
          ms_tick_o <= 1'b0;
        end else begin
          ms_tick_o <= 1'b0;
          if (tick_i) begin
            if (cnt_q == DW'(TICK_DIV - 1)) begin
              cnt_q     <= '0;
              ms_tick_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer
  import toggle_wdog_pkg::*;
#(
  parameter int unsigned BASE_MS = 125,
  parameter int unsigned CW      = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          ms_tick_i,
  input  logic [2:0]    code_i,
  output logic          early_o,
  output logic          late_o,
  output logic [CW-1:0] elapsed_o
);
  logic [CW-1:0] lo_w, hi_w;
  int unsigned   p;

  always_comb begin
    p    = period_ms(code_i, BASE_MS);
    lo_w = CW'(p - p / 4);
    hi_w = CW'(p + p / 4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   elapsed_o <= '0;
    else if (!run_i || restart_i)  elapsed_o <= '0;
    else if (ms_tick_i)            elapsed_o <= elapsed_o + 1'b1;
  end

  assign early_o = elapsed_o < lo_w;
  assign late_o  = elapsed_o > hi_w;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import toggle_wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       fault_i,
  input  logic       accept_i,
  output logic       en_o,
  output logic       irq_en_o,
  output logic [2:0] code_o,
  output logic       status_o,
  output logic       exp_o,
  output logic [7:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      irq_en_o <= 1'b0;
      code_o   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        en_o     <= wdata_i[0];
        irq_en_o <= wdata_i[1];
      end
      if (addr_i == A_CODE) code_o <= wdata_i[2:0];
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             status_o <= 1'b0;
    else if (fault_i)                                        status_o <= 1'b1;
    else if (wr_en_i && addr_i == A_STAT && wdata_i[0])      status_o <= 1'b0;
  end

  // value the next refresh must carry; 1 after enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       exp_o <= 1'b1;
    else if (!en_o)    exp_o <= 1'b1;
    else if (accept_i) exp_o <= ~exp_o;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {6'b0, irq_en_o, en_o};
      A_TRIG:  rdata_o = {7'b0, ~exp_o};
      A_CODE:  rdata_o = {5'b0, code_o};
      default: rdata_o = {7'b0, status_o};
    endcase
  end
endmodule

// File: rtl/toggle_wdog.sv
module toggle_wdog
  import toggle_wdog_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50,
  parameter int unsigned BASE_MS  = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       timeout_o,
  output logic       irq_o
);
  localparam int unsigned MAX_P = BASE_MS << MAX_CODE;
  localparam int unsigned CW    = $clog2(MAX_P + MAX_P / 4 + 2);

  logic          ms_tick, early, late;
  logic [CW-1:0] elapsed;
  logic          en, irq_en, status, exp_val;
  logic [2:0]    code;
  logic          trig_wr, bad, fault, accept, restart;

  assign trig_wr = wr_en_i && addr_i == A_TRIG && en;
  assign bad     = trig_wr && (early || wdata_i[0] != exp_val);
  assign fault   = bad || (en && late);
  assign accept  = trig_wr && !bad;
  assign restart = trig_wr || late;

  wdog_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ms_tick_o(ms_tick)
  );

  wdog_window_timer #(.BASE_MS(BASE_MS), .CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en), .restart_i(restart),
    .ms_tick_i(ms_tick), .code_i(code), .early_o(early), .late_o(late),
    .elapsed_o(elapsed)
  );

  wdog_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .fault_i(fault), .accept_i(accept), .en_o(en),
    .irq_en_o(irq_en), .code_o(code), .status_o(status), .exp_o(exp_val),
    .rdata_o(rdata_o)
  );

  assign timeout_o = status;
  assign irq_o     = status & irq_en;
endmodule

// File: rtl/toggle_wdog_chk.sv
module toggle_wdog_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          timeout_o,
  input logic          irq_o,
  input logic          en,
  input logic          late,
  input logic          exp_val,
  input logic [CW-1:0] elapsed
);
  a_r7_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> timeout_o);

  a_r6_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !(wr_en_i && addr_i == 2'd3 && wdata_i[0]) |=> timeout_o);

  a_r8_idle_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> elapsed == '0);

  a_r4_late_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && late |=> timeout_o && elapsed == '0);

  a_r5_repeat_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && wr_en_i && addr_i == 2'd1 && wdata_i[0] != exp_val |=> timeout_o);

  a_r8_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !timeout_o |=> !timeout_o);
endmodule

bind toggle_wdog toggle_wdog_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .timeout_o(timeout_o), .irq_o(irq_o), .en(en),
  .late(late), .exp_val(exp_val), .elapsed(elapsed)
);

// File: tb/toggle_wdog_tb.sv
module toggle_wdog_tb_top;
  localparam int unsigned DIV  = 2;
  localparam int unsigned BASE = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       timeout_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  toggle_wdog #(.TICK_DIV(DIV), .BASE_MS(BASE)) dut_i (.*);

  // {code[2:0], wait_ms[7:0], value, fault}; windows: P=8<<code, [P-P/4, P+P/4]
  localparam logic [12:0] VEC [13] = '{
    {3'd0, 8'd5,   1'b1, 1'b1},
    {3'd0, 8'd6,   1'b1, 1'b0},
    {3'd0, 8'd10,  1'b1, 1'b0},
    {3'd0, 8'd8,   1'b0, 1'b1},
    {3'd1, 8'd11,  1'b1, 1'b1},
    {3'd1, 8'd20,  1'b1, 1'b0},
    {3'd2, 8'd23,  1'b1, 1'b1},
    {3'd2, 8'd24,  1'b1, 1'b0},
    {3'd3, 8'd80,  1'b1, 1'b0},
    {3'd4, 8'd96,  1'b1, 1'b0},
    {3'd5, 8'd95,  1'b1, 1'b1},
    {3'd5, 8'd96,  1'b1, 1'b0},
    {3'd7, 8'd160, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic advance_ms(input int n);
    repeat (n * DIV) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic arm(input logic [2:0] code, input logic irq);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd1);
    wr(2'd2, {5'b0, code});
    wr(2'd0, {6'b0, irq, 1'b1});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reset reg", d, 8'd0);
    end
    check("R1 timeout_o", {7'b0, timeout_o}, 8'd0);
    check("R1 irq_o", {7'b0, irq_o}, 8'd0);

    // R2 R3 R5 window and value vectors
    for (int i = 0; i < 13; i++) begin
      arm(VEC[i][12:10], 1'b0);
      advance_ms(int'(VEC[i][9:2]));
      wr(2'd1, {7'b0, VEC[i][1]});
      @(negedge clk_i);
      check($sformatf("R3/R2/R5 vec%0d", i), {7'b0, timeout_o}, {7'b0, VEC[i][0]});
    end

    // R5 alternation then repeat
    arm(3'd0, 1'b0);
    advance_ms(8); wr(2'd1, 8'd1);
    advance_ms(8); wr(2'd1, 8'd0);
    advance_ms(8); wr(2'd1, 8'd1);
    check("R5 alternating ok", {7'b0, timeout_o}, 8'd0);
    rd(2'd1, d);
    check("R5 trigger readback", d, 8'd1);
    advance_ms(8); wr(2'd1, 8'd1);
    check("R5 repeat faults", {7'b0, timeout_o}, 8'd1);

    // R4 late
    arm(3'd0, 1'b0);
    advance_ms(10);
    check("R4 at edge no fault", {7'b0, timeout_o}, 8'd0);
    advance_ms(1);
    check("R4 late faults", {7'b0, timeout_o}, 8'd1);
    wr(2'd3, 8'd1);
    advance_ms(8); wr(2'd1, 8'd1);
    check("R4 count restarted", {7'b0, timeout_o}, 8'd0);

    // R7 irq gating
    arm(3'd0, 1'b0);
    advance_ms(11);
    check("R7 irq masked", {6'b0, irq_o, timeout_o}, 8'd1);
    wr(2'd0, 8'd3);
    check("R7 irq raised", {6'b0, irq_o, timeout_o}, 8'd3);

    // R6 sticky and clear
    wr(2'd3, 8'd0);
    check("R6 write 0 keeps", {7'b0, timeout_o}, 8'd1);
    wr(2'd3, 8'd1);
    rd(2'd3, d);
    check("R6 write 1 clears", d, 8'd0);

    // R8 disabled: writes ignored, no timeout
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd0);
    advance_ms(40);
    check("R8 disabled no fault", {7'b0, timeout_o}, 8'd0);
    rd(2'd1, d);
    check("R8 trigger ignored", d, 8'd0);

    // R8 enable restarts window
    arm(3'd0, 1'b0);
    advance_ms(7);
    wr(2'd0, 8'd0); wr(2'd0, 8'd1);
    advance_ms(7); wr(2'd1, 8'd1);
    check("R8 restart on enable", {7'b0, timeout_o}, 8'd0);

    // R9 prescaler: DIV-1 extra pulses short of a ms leave count unchanged
    arm(3'd0, 1'b0);
    advance_ms(5);
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    wr(2'd1, 8'd1);
    check("R9 partial tick no step", {7'b0, timeout_o}, 8'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule